// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of up to eight fans by timing their tachometer signals. A slow reference tick, divided down from the system clock, is counted over one full revolution of a fan, which is two tachometer pulses. A slow fan gives a large count and a fast fan a small one. Each channel has its own prescale divisor of 1, 2, 4 or 8, applied to the reference tick, so slow fans can still be resolved within the 8-bit range.

A single counter serves all channels. The channels are visited in turn, one measurement at a time, and each result lands in a per-channel count register. A channel whose pin has been given over to general-purpose I/O is removed from measurement through its enable input and keeps its last result. A count above the channel's programmed limit raises a sticky status bit, which software clears by writing a one. The tachometer inputs arrive asynchronously and are synchronized inside the block. Registers are reached through a plain parallel write port and a combinational read port.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every count register reads 0, every limit register reads 255, both divisor registers read 0 and the status register reads 0.
- R2: The reference tick fires once every TICK_DIV system clocks. A channel's stored count is the number of scaled ticks from one rising tach edge to the second rising edge after it, which spans two tach periods (one revolution), within one count of that figure.
- R3: Divisor fields are 2 bits wide. Channel n uses bits [2(n%4)+1 : 2(n%4)] of register 0x10 (channels 0 to 3) or 0x11 (channels 4 to 7). The codes 0, 1, 2 and 3 make the count advance once every 1, 2, 4 or 8 reference ticks.
- R4: When a measurement window would reach 255 counts or more, the stored count is 255.
- R5: When a channel sees no rising edge while 255 scaled ticks elapse, the stored count is 255, which marks a stalled fan.
- R6: A channel whose enable is low is skipped. Its count register keeps its value and its status bit is not set.
- R7: Enabled channels are measured one at a time in ascending order, wrapping from the last channel to channel 0, and every enabled channel is updated in each pass.
- R8: When a stored count is strictly greater than the channel's limit (registers 0x08 to 0x0F for channels 0 to 7), status bit n of register 0x12 is set. A count equal to the limit sets nothing.
- R9: Writing register 0x12 clears every status bit written as 1 and leaves the bits written as 0 unchanged. A new setting in the same cycle takes priority over a clear.
- R10: Count registers 0x00 to 0x07 are read-only, and writes to them are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_i | input | NUM_CH | Raw tachometer signals, one per channel |
| chan_en_i | input | NUM_CH | Per-channel measurement enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |

## Verification
The hardest case to reach from the ports is a status bit that must stay clear after a write-one clear, even though the channel keeps being measured. The stimulus reaches it by first raising that channel's limit above its steady count, then clearing the bit, and then letting another full pass run. A second awkward case is a channel disabled partway through a measurement: its tach period is changed and its count register is written while it is disabled, and after several passes of the other channels the old value must still be there. Each divisor and saturation case uses tach periods chosen so that the expected count follows from the period alone, with a one-count allowance for the tick phase.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

   // state of the shared period meter
   typedef enum logic [1:0] {
      MS_PICK = 2'd0,
      MS_ARM  = 2'd1,
      MS_RUN  = 2'd2
   } meter_state_e;

   // prescale limit (ticks per count minus one) for a 2-bit divisor code
   function automatic logic [2:0] pre_limit(input logic [1:0] code);
      case (code)
         2'd0:    pre_limit = 3'd0;
         2'd1:    pre_limit = 3'd1;
         2'd2:    pre_limit = 3'd3;
         default: pre_limit = 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/fan_tick_gen.sv
module fan_tick_gen #(
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (TICK_DIV <= 1) begin : g_every
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
         assign tick_o = tick_q;
      end else begin : g_div
         localparam int unsigned TW = $clog2(TICK_DIV);
         localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tach_i,
   output logic [NUM_CH-1:0] rise_o
);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic [SYNC_STAGES-1:0] chain_q;
         logic                   prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
               prev_q  <= 1'b0;
            end else begin
               chain_q <= {chain_q[SYNC_STAGES-2:0], tach_i[g]};
               prev_q  <= chain_q[SYNC_STAGES-1];
            end
         end
         assign rise_o[g] = chain_q[SYNC_STAGES-1] & ~prev_q;
      end
   endgenerate

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
   import fan_tach_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned COUNT_W = 8,
   localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick_i,
   input  logic [NUM_CH-1:0]            rise_i,
   input  logic [NUM_CH-1:0]            en_i,
   input  logic [NUM_CH-1:0][1:0]       div_sel_i,
   output logic                         upd_o,
   output logic [CH_W-1:0]              upd_ch_o,
   output logic [COUNT_W-1:0]           upd_val_o
);

   localparam int unsigned FULL = (1 << COUNT_W) - 1;
   localparam logic [COUNT_W-1:0] FULL_V = COUNT_W'(FULL);
   localparam logic [COUNT_W-1:0] NEAR_V = COUNT_W'(FULL - 1);
   localparam logic [CH_W-1:0]    LAST_CH = CH_W'(NUM_CH - 1);

   meter_state_e       state_q;
   logic [CH_W-1:0]    ch_q;
   logic [COUNT_W-1:0] cnt_q;
   logic [2:0]         pre_q;
   logic               seen_q;

   logic               cur_en, cur_rise, step, done;
   logic [2:0]         lim;
   logic [CH_W-1:0]    next_ch;
   logic [COUNT_W-1:0] done_val;

   assign cur_en   = en_i[ch_q];
   assign cur_rise = rise_i[ch_q];
   assign lim      = pre_limit(div_sel_i[ch_q]);
   assign step     = tick_i && (pre_q == lim);
   assign next_ch  = (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;

   // completion of the current channel's measurement
   always_comb begin
      done     = 1'b0;
      done_val = FULL_V;
      if (cur_en) begin
         case (state_q)
            MS_ARM: begin
               if (!cur_rise && step && cnt_q == NEAR_V) done = 1'b1;
            end
            MS_RUN: begin
               if (cur_rise && seen_q) begin
                  done     = 1'b1;
                  done_val = cnt_q;
               end else if (!cur_rise && step && cnt_q == NEAR_V) begin
                  done = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_PICK;
         ch_q    <= '0;
         cnt_q   <= '0;
         pre_q   <= '0;
         seen_q  <= 1'b0;
      end else begin
         case (state_q)
            MS_PICK: begin
               cnt_q  <= '0;
               pre_q  <= '0;
               seen_q <= 1'b0;
               if (cur_en) state_q <= MS_ARM;
               else        ch_q    <= next_ch;
            end
            MS_ARM: begin
               if (!cur_en || done) begin
                  state_q <= MS_PICK;
                  ch_q    <= next_ch;
               end else if (cur_rise) begin
                  state_q <= MS_RUN;
                  cnt_q   <= '0;
                  pre_q   <= '0;
                  seen_q  <= 1'b0;
               end else if (tick_i) begin
                  pre_q <= step ? 3'd0 : pre_q + 3'd1;
                  if (step) cnt_q <= cnt_q + 1'b1;
               end
            end
            MS_RUN: begin
               if (!cur_en || done) begin
                  state_q <= MS_PICK;
                  ch_q    <= next_ch;
               end else begin
                  if (cur_rise) seen_q <= 1'b1;
                  if (tick_i) begin
                     pre_q <= step ? 3'd0 : pre_q + 3'd1;
                     if (step) cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= MS_PICK;
            end
         endcase
      end
   end

   assign upd_o     = done;
   assign upd_ch_o  = ch_q;
   assign upd_val_o = done_val;

endmodule

// File: rtl/fan_tach_regs.sv
module fan_tach_regs #(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned COUNT_W = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         upd_i,
   input  logic [CH_W-1:0]              upd_ch_i,
   input  logic [COUNT_W-1:0]           upd_val_i,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   input  logic [ADDR_W-1:0]            rd_addr_i,
   output logic [DATA_W-1:0]            rd_data_o,
   output logic [NUM_CH-1:0][1:0]       div_sel_o,
   output logic [NUM_CH-1:0][COUNT_W-1:0] value_o,
   output logic [NUM_CH-1:0][COUNT_W-1:0] limit_o,
   output logic [NUM_CH-1:0]            status_o
);

   localparam int unsigned LIM_BASE  = NUM_CH;
   localparam int unsigned DIV_BASE  = 2 * NUM_CH;
   localparam int unsigned DIV_REGS  = (NUM_CH + 3) / 4;
   localparam int unsigned STAT_ADDR = DIV_BASE + DIV_REGS;

   generate
      if (STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("fan_tach_regs: ADDR_W too narrow for the register map");
      end
      if (DATA_W < 8 || DATA_W < NUM_CH || DATA_W < COUNT_W) begin : g_bad_data
         $error("fan_tach_regs: DATA_W too narrow");
      end
   endgenerate

   logic [NUM_CH-1:0][COUNT_W-1:0] value_q, limit_q;
   logic [NUM_CH-1:0][1:0]         div_q;
   logic [NUM_CH-1:0]              status_q, set_m, clr_m;
   logic                           stat_wr;

   assign stat_wr = wr_en_i && (wr_addr_i == ADDR_W'(STAT_ADDR));

   always_comb begin
      set_m = '0;
      if (upd_i && (upd_val_i > limit_q[upd_ch_i])) set_m[upd_ch_i] = 1'b1;
      clr_m = stat_wr ? wr_data_i[NUM_CH-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q  <= '0;
         limit_q  <= '1;
         div_q    <= '0;
         status_q <= '0;
      end else begin
         if (upd_i) value_q[upd_ch_i] <= upd_val_i;
         for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wr_en_i && wr_addr_i == ADDR_W'(LIM_BASE + ch))
               limit_q[ch] <= wr_data_i[COUNT_W-1:0];
            if (wr_en_i && wr_addr_i == ADDR_W'(DIV_BASE + ch / 4))
               div_q[ch] <= wr_data_i[2*(ch%4) +: 2];
         end
         status_q <= (status_q & ~clr_m) | set_m;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (rd_addr_i == ADDR_W'(ch))
            rd_data_o[COUNT_W-1:0] = value_q[ch];
         if (rd_addr_i == ADDR_W'(LIM_BASE + ch))
            rd_data_o[COUNT_W-1:0] = limit_q[ch];
         if (rd_addr_i == ADDR_W'(DIV_BASE + ch / 4))
            rd_data_o[2*(ch%4) +: 2] = div_q[ch];
      end
      if (rd_addr_i == ADDR_W'(STAT_ADDR))
         rd_data_o[NUM_CH-1:0] = status_q;
   end

   assign div_sel_o = div_q;
   assign value_o   = value_q;
   assign limit_o   = limit_q;
   assign status_o  = status_q;

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned COUNT_W     = 8,
   parameter int unsigned TICK_DIV    = 1000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tach_i,
   input  logic [NUM_CH-1:0] chan_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("fan_tach_monitor: NUM_CH must be 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fan_tach_monitor: SYNC_STAGES must be at least 2");
      end
      if (COUNT_W < 2 || COUNT_W > DATA_W) begin : g_bad_cnt
         $error("fan_tach_monitor: COUNT_W out of range");
      end
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("fan_tach_monitor: TICK_DIV must be positive");
      end
   endgenerate

   logic                           tick_w;
   logic [NUM_CH-1:0]              rise_w;
   logic                           upd_w;
   logic [CH_W-1:0]                upd_ch_w;
   logic [COUNT_W-1:0]             upd_val_w;
   logic [NUM_CH-1:0][1:0]         div_sel_w;
   logic [NUM_CH-1:0][COUNT_W-1:0] value_w, limit_w;
   logic [NUM_CH-1:0]              status_w;

   fan_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick_w)
   );

   fan_tach_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tach_i (tach_i),
      .rise_o (rise_w)
   );

   fan_period_meter #(.NUM_CH(NUM_CH), .COUNT_W(COUNT_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_w),
      .rise_i    (rise_w),
      .en_i      (chan_en_i),
      .div_sel_i (div_sel_w),
      .upd_o     (upd_w),
      .upd_ch_o  (upd_ch_w),
      .upd_val_o (upd_val_w)
   );

   fan_tach_regs #(
      .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_i     (upd_w),
      .upd_ch_i  (upd_ch_w),
      .upd_val_i (upd_val_w),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o),
      .div_sel_o (div_sel_w),
      .value_o   (value_w),
      .limit_o   (limit_w),
      .status_o  (status_w)
   );

endmodule

// File: rtl/fan_tach_chk.sv
module fan_tach_chk #(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned COUNT_W = 8,
   parameter int unsigned CH_W    = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_CH-1:0]              chan_en,
   input logic                           upd,
   input logic [CH_W-1:0]                upd_ch,
   input logic [COUNT_W-1:0]             upd_val,
   input logic [NUM_CH-1:0][COUNT_W-1:0] value,
   input logic [NUM_CH-1:0][COUNT_W-1:0] limit,
   input logic [NUM_CH-1:0]              status
);

   // R6
   upd_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> chan_en[upd_ch]);

   // R7
   rr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (int'(upd_ch) == (int'($past(upd_ch)) + 1) % NUM_CH));

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && upd_val > limit[upd_ch]) |=> status[$past(upd_ch)]);

   // R8
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~$past(status))) |-> $past(upd));

   // R10
   value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(value));

endmodule

bind fan_tach_monitor fan_tach_chk #(
   .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .CH_W(CH_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .chan_en (chan_en_i),
   .upd     (upd_w),
   .upd_ch  (upd_ch_w),
   .upd_val (upd_val_w),
   .value   (value_w),
   .limit   (limit_w),
   .status  (status_w)
);

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int NCH        = 8;
   localparam int WAIT_PASS  = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   wire  [7:0] tach;
   logic [7:0] chan_en = '0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;

   int per [NCH];
   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fan_tach_monitor #(.TICK_DIV(TICK_DIV)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tach_i    (tach),
      .chan_en_i (chan_en),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   // tach generators: period in clocks, 0 holds the line low
   for (genvar g = 0; g < NCH; g++) begin : g_tach
      logic t = 1'b0;
      assign tach[g] = t;
      initial begin
         forever begin
            if (per[g] == 0) begin
               t = 1'b0;
               @(negedge clk);
            end else begin
               t = 1'b1;
               repeat (per[g] / 2) @(negedge clk);
               t = 1'b0;
               repeat (per[g] - per[g] / 2) @(negedge clk);
            end
         end
      end
   end

   task automatic chk(input string req, input int got, input int lo, input int hi);
      checks++;
      if (got < lo || got > hi) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      rd_addr = 5'(a);
      #1;
      d = int'(rd_data);
   endtask

   // expected count window for a period p (clocks) and divisor d
   task automatic exp_range(input int p, input int d, output int lo, output int hi);
      int num, den;
      if (p == 0) begin
         lo = 255; hi = 255;
      end else begin
         num = 2 * p;
         den = TICK_DIV * d;
         lo = num / den - 1;
         hi = (num + den - 1) / den + 1;
         if (lo < 0) lo = 0;
         if (lo > 255) lo = 255;
         if (hi > 255) hi = 255;
      end
   endtask

   task automatic t_reset();
      int v;
      for (int c = 0; c < NCH; c++) begin
         rd(c, v);       chk("R1 count", v, 0, 0);
         rd(8 + c, v);   chk("R1 limit", v, 255, 255);
      end
      rd(16, v); chk("R1 div lo", v, 0, 0);
      rd(17, v); chk("R1 div hi", v, 0, 0);
      rd(18, v); chk("R1 status", v, 0, 0);
   endtask

   task automatic t_divisor();
      int v, lo, hi;
      for (int c = 0; c < NCH; c++) per[c] = 200;
      wr(16, 8'hE4);
      wr(17, 8'hE4);
      rd(16, v); chk("R3 div readback", v, 8'hE4, 8'hE4);
      chan_en = 8'hFF;
      repeat (WAIT_PASS) @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         exp_range(200, 1 << (c % 4), lo, hi);
         rd(c, v);
         chk("R2 R3 R7 scaled count", v, lo, hi);
      end
   endtask

   task automatic t_periods();
      int v, lo, hi;
      int p [NCH] = '{100, 300, 500, 600, 1000, 0, 150, 250};
      wr(16, 0);
      wr(17, 0);
      for (int c = 0; c < NCH; c++) per[c] = p[c];
      repeat (WAIT_PASS) @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         exp_range(p[c], 1, lo, hi);
         rd(c, v);
         if (c == 3 || c == 4) chk("R4 saturated count", v, lo, hi);
         else if (c == 5)      chk("R5 stalled fan", v, lo, hi);
         else                  chk("R2 period count", v, lo, hi);
      end
   endtask

   task automatic t_limits();
      int v;
      wr(8 + 2, 200);
      wr(8 + 3, 254);
      repeat (WAIT_PASS) @(posedge clk);
      rd(18, v); chk("R8 over-limit flags, equal not flagged", v, 8'h0C, 8'h0C);
      wr(18, 8'h00);
      rd(18, v); chk("R9 zero write keeps flags", v, 8'h0C, 8'h0C);
      wr(8 + 2, 255);
      wr(18, 8'h04);
      rd(18, v); chk("R9 write-one clears bit", v, 8'h08, 8'h08);
      repeat (WAIT_PASS) @(posedge clk);
      rd(18, v); chk("R8 R9 cleared bit stays clear", v, 8'h08, 8'h08);
   endtask

   task automatic t_disable();
      int v, lo, hi;
      chan_en[6] = 1'b0;
      per[6] = 400;
      per[7] = 100;
      wr(8 + 6, 10);
      wr(6, 8'h11);
      exp_range(150, 1, lo, hi);
      rd(6, v); chk("R10 count write ignored", v, lo, hi);
      repeat (WAIT_PASS) @(posedge clk);
      rd(6, v); chk("R6 disabled count held", v, lo, hi);
      rd(18, v); chk("R6 disabled no flag", v & 8'h40, 0, 0);
      exp_range(100, 1, lo, hi);
      rd(7, v); chk("R7 neighbour still updated", v, lo, hi);
      rd(31, v); chk("R10 unmapped read", v, 0, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) per[c] = 0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_divisor();
      t_periods();
      t_limits();
      t_disable();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule